// File: doc/BRIEF.md
# Sticky-Pending Masked Interrupt Aggregator

This block gathers a bank of level-sensitive interrupt request lines into a single interrupt for a small processor. Each line is brought into the clock domain through a two-stage synchronizer. The synchronized copy is held as a live level image. A pending register accumulates that image every cycle, so a line that was seen high stays pending after it drops. A mask register chooses which pending bits may reach the processor. The processor interrupt is a registered OR of the pending bits that are enabled.

Software works through a small word-addressed register port. It can read the mask, the pending bits and the live level image. It can rewrite the mask and acknowledge pending bits by writing ones to them. An acknowledge of a line that is still high does not stick, because the live level is merged into pending again in the same update.

For diagnostics, each line has an event counter that counts low-to-high transitions of the synchronized level. Software first writes a line number to a select register and then reads the selected counter through the port.

Top module: `irq_latch_ctrl`

## Requirements
- R1: There are N_LINES request lines (default 32). Line n maps to bit n of the mask, pending and live-level registers; line 31 maps to bit 31.
- R2: The live-level register (address 2, read-only) shows each synchronized line as 1 while it is high and 0 while it is low.
- R3: Pending bits set by a line stay set after the line falls. Only an acknowledge or a reset clears them.
- R4: cpu_irq is 1 exactly when (pending AND mask) is nonzero. It is registered, so it reflects the pending and mask values of the previous cycle.
- R5: A write to address 1 clears each pending bit whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R6: After an acknowledge, the live level is merged back into pending, so a line that is still high keeps its pending bit.
- R7: A write to address 0 replaces the whole mask. cpu_irq follows the new mask one cycle after the mask register updates.
- R8: Reset (rst_n low) clears the mask, pending, live level, counter select and all counters, and drives cpu_irq and rvalid to 0.
- R9: Each line's counter increments once per low-to-high transition of its synchronized level. Holding a line high adds nothing.
- R10: The counters are CNT_W bits wide and wrap to 0 on overflow.
- R11: A line that rises is visible in the live level after two clock edges and in pending after three. cpu_irq follows one edge after pending.
- R12: Register map: 0 mask (read/write), 1 pending (read / write-one-to-clear), 2 live level (read-only), 3 counter select (read/write, low bits), 4 selected counter (read-only, zero-extended). Writes to 2 and 4 have no effect, and reads of 5 to 7 return 0. rvalid and rdata appear the cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | N_LINES | Level-sensitive request lines, asynchronous |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| cpu_irq | output | 1 | Interrupt to the processor |

## Verification
The bench uses the full 32-line width, so the top bit position and the counter select over all lines are both covered. It narrows CNT_W to 4, so a line pulsed seventeen times wraps its counter back to 1 within a short run. Exact-cycle sampling of cpu_irq after a line rises pins down the synchronizer and pending latency. Acknowledges issued while a line is still held high show that the pending bit is latched again.

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
  parameter int N_LINES = 32,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_lines,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [2:0]         addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic               rvalid,
  output logic               cpu_irq
);
  localparam int SEL_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  logic [N_LINES-1:0] sync1, raw, raw_d, pending, mask, ack;
  logic [SEL_W-1:0]   sel;
  logic [CNT_W-1:0]   cnt [N_LINES];
  logic [31:0]        mask_x, pend_x, raw_x, sel_x, cnt_x, rd_mux;

  assign ack = (wr_en && addr == 3'd1) ? wdata[N_LINES-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= '0;
      raw     <= '0;
      raw_d   <= '0;
      pending <= '0;
      mask    <= '0;
      sel     <= '0;
      cpu_irq <= 1'b0;
    end else begin
      sync1   <= irq_lines;
      raw     <= sync1;
      raw_d   <= raw;
      pending <= (pending & ~ack) | raw;
      cpu_irq <= |(pending & mask);
      if (wr_en && addr == 3'd0) mask <= wdata[N_LINES-1:0];
      if (wr_en && addr == 3'd3) sel  <= wdata[SEL_W-1:0];
    end
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt[i] <= '0;
      else if (raw[i] && !raw_d[i]) cnt[i] <= cnt[i] + 1'b1;
    end
  end

  always_comb begin
    mask_x = '0; mask_x[N_LINES-1:0] = mask;
    pend_x = '0; pend_x[N_LINES-1:0] = pending;
    raw_x  = '0; raw_x[N_LINES-1:0]  = raw;
    sel_x  = '0; sel_x[SEL_W-1:0]    = sel;
    cnt_x  = '0; cnt_x[CNT_W-1:0]    = cnt[sel];
    case (addr)
      3'd0:    rd_mux = mask_x;
      3'd1:    rd_mux = pend_x;
      3'd2:    rd_mux = raw_x;
      3'd3:    rd_mux = sel_x;
      3'd4:    rd_mux = cnt_x;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk #(
  parameter int N_LINES = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               rd_en,
  input logic [2:0]         addr,
  input logic [31:0]        wdata,
  input logic               rvalid,
  input logic               cpu_irq,
  input logic [N_LINES-1:0] pending,
  input logic [N_LINES-1:0] mask,
  input logic [N_LINES-1:0] raw
);
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 3'd1) |=> ((pending & $past(pending)) == $past(pending)));

  p_relatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pending & $past(raw)) == $past(raw)));

  p_irq_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cpu_irq == |($past(pending) & $past(mask))));

  p_mask_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0) |=> (mask == $past(wdata[N_LINES-1:0])));

  p_rvalid_on_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);

  p_rvalid_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);
endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(.N_LINES(N_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rvalid(rvalid), .cpu_irq(cpu_irq),
  .pending(pending), .mask(mask), .raw(raw)
);

// File: tb/tb_irq_latch_ctrl.sv
module tb_irq_latch_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 32;
  localparam int CW = 4;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [NL-1:0] irq_lines = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          rvalid, cpu_irq;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  int          exp_cnt [NL];
  logic [NL-1:0] cur = '0, exp_pend = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_latch_ctrl #(.N_LINES(NL), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rvalid(rvalid), .cpu_irq(cpu_irq));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) check("R12 unexpected rvalid", 32'd1, 32'd0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lines(logic [NL-1:0] v);
    @(negedge clk);
    for (int i = 0; i < NL; i++) if (v[i] && !cur[i]) exp_cnt[i]++;
    cur = v; irq_lines = v;
  endtask

  task automatic settle();
    cyc(5);
    exp_pend |= cur;
  endtask

  task automatic ack(logic [NL-1:0] w);
    wr(3'd1, w);
    exp_pend = (exp_pend & ~w) | cur;
    cyc(2);
  endtask

  task automatic cnt_chk(int line, string tag);
    wr(3'd3, line);
    rd(3'd4, exp_cnt[line] % (1 << CW), tag);
  endtask

  task automatic pulse(int line, int times);
    for (int k = 0; k < times; k++) begin
      lines(cur | (NL'(1) << line)); cyc(4);
      lines(cur & ~(NL'(1) << line)); cyc(4);
    end
    exp_pend[line] = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) exp_cnt[i] = 0;
    cyc(3); rst_n = 1'b1; cyc(1);
    // R8 reset state
    check("R8 cpu_irq after reset", cpu_irq, 0);
    check("R8 rvalid after reset", rvalid, 0);
    rd(3'd0, 0, "R8 mask reset");
    rd(3'd1, 0, "R8 pending reset");
    rd(3'd2, 0, "R8 raw reset");
    rd(3'd3, 0, "R8 select reset");
    rd(3'd4, 0, "R8 counter reset");

    // R2 R3 R4 levels into pending, masked off
    lines(32'h0000_0005); settle();
    rd(3'd2, 32'h5, "R2 raw level");
    rd(3'd1, exp_pend, "R3 pending set");
    check("R4 irq masked off", cpu_irq, 0);

    // R11 latency, R7 mask
    wr(3'd0, 32'h0000_0100);
    cyc(2);
    check("R4 no enabled pending", cpu_irq, 0);
    lines(cur | 32'h100);
    cyc(3);
    check("R11 irq not before 4th edge", cpu_irq, 0);
    cyc(1);
    check("R11 irq at 4th edge", cpu_irq, 1);
    exp_pend |= cur;

    // R3 sticky after fall
    lines(32'h0); settle();
    rd(3'd2, 0, "R2 raw cleared");
    rd(3'd1, exp_pend, "R3 pending sticky");
    check("R4 irq held by sticky pending", cpu_irq, 1);

    // R5 acknowledge
    ack(32'h0000_0100);
    rd(3'd1, 32'h5, "R5 ack clears only ones");
    check("R5 irq drops after ack", cpu_irq, 0);

    // R6 ack while high
    lines(32'h8); settle();
    ack(32'h8);
    rd(3'd1, 32'hD, "R6 relatched while high");
    lines(32'h0); settle();
    ack(32'h8);
    rd(3'd1, 32'h5, "R6 clears once low");

    // R7 mask replacement
    wr(3'd0, 32'hFFFF_0000);
    wr(3'd0, 32'h0000_0004);
    rd(3'd0, 32'h4, "R7 mask replaced");
    cyc(1);
    check("R7 irq with new mask", cpu_irq, 1);
    wr(3'd0, 32'h0);
    cyc(1);
    check("R7 irq cleared by mask", cpu_irq, 0);

    // R1 top line
    lines(32'h8000_0000); settle();
    rd(3'd2, 32'h8000_0000, "R1 line 31 raw");
    rd(3'd1, exp_pend, "R1 line 31 pending");
    lines(32'h0); settle();

    // R12 ignored writes and unmapped reads
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, 0, "R12 raw write ignored");
    wr(3'd3, 0);
    wr(3'd4, 32'h7);
    rd(3'd4, exp_cnt[0] % (1 << CW), "R12 counter write ignored");
    rd(3'd5, 0, "R12 unmapped read 5");
    rd(3'd7, 0, "R12 unmapped read 7");

    // R9 counters
    cnt_chk(0, "R9 line 0 one edge");
    cnt_chk(2, "R9 line 2 one edge");
    pulse(5, 3);
    cnt_chk(5, "R9 line 5 three edges");
    lines(cur | (NL'(1) << 6)); cyc(20);
    lines(cur & ~(NL'(1) << 6)); cyc(4);
    cnt_chk(6, "R9 held high counts once");
    cnt_chk(31, "R9 line 31 one edge");

    // R10 wrap
    pulse(7, 17);
    cnt_chk(7, "R10 counter wraps");
    rd(3'd3, 7, "R12 select readback");

    cyc(4);
    check("R12 read queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule